// File: doc/BRIEF.md
# Trigger-Windowed Frame Hit Buffer

This block holds a continuous stream of 16-bit hit-address words in a circular data store. The store is split into readout frames by a frame-start strobe. Each frame-start strobe records, in a per-frame table, the data index at which the new frame begins. Each accepted trigger records its trigger time and the frame that was current when it arrived. The triggers wait in a first-in first-out table.

When readout is requested, the block takes the oldest trigger and walks two consecutive frames: the trigger's own frame and the frame after it. A word from the first frame is selected when its low 12 address bits exceed the trigger time. A word from the second frame is selected when its low 12 address bits are below the trigger time. The selected words leave on a valid/last stream. After a trigger completes, the data it protected may be overwritten.

A full flag warns the producer when either table would overflow. Sensor deserialisation and event formatting sit outside the block.

Top module: `win_hit_buffer`

## Requirements
- R1: An accepted hit is written at the next data index. While the data store is full, a hit is dropped. The store is full when the number of words written since the oldest protected frame start equals the data depth (2^DMEM_AW).
- R2: A frame-start strobe makes the frame in frame_cnt_i current. A hit in the same cycle as the strobe belongs to the new frame. A trigger in the same cycle as the strobe belongs to the frame that was current before it.
- R3: For a trigger with time T taken in frame F, the output carries, in write order, the words of frame F whose bits [11:0] are greater than T. These are followed by the words of frame F+1 whose bits [11:0] are less than T. Bits [15:12] play no part in the test, and a word whose bits [11:0] equal T is never selected.
- R4: Each trigger completes with exactly one cycle that has out_last_o=1. If it selected words, that cycle carries its final word with out_valid_o=1. If it selected none, that cycle has out_valid_o=0 and forms an empty completion marker.
- R5: Extraction of a trigger starts only when rd_req_i is 1, the trigger is the oldest pending one, and the current frame is at least two frames past the trigger's frame. Triggers complete in arrival order.
- R6: full_o is 1 while the trigger table holds 2^TRIG_AW entries or the data store is full. A trigger that arrives while full_o is 1, or before the first frame-start strobe, is dropped.
- R7: While rd_req_i is 0, no extraction starts. At least ten pending triggers are kept intact and complete correctly once rd_req_i returns to 1.
- R8: Once a trigger completes, its frames are no longer protected. With no trigger pending, only the current frame is protected, so a frame-start strobe clears a data-full condition.
- R9: After reset, out_valid_o, out_last_o and full_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hit_valid_i | input | 1 | A hit word is present |
| hit_data_i | input | DATA_W | Hit word; bits [CMP_W-1:0] are the address |
| frame_start_i | input | 1 | Start of a new frame |
| frame_cnt_i | input | FRAME_AW | Number of the frame that starts; it advances by one each time |
| trig_i | input | 1 | Trigger strobe |
| trig_time_i | input | CMP_W | Trigger time, compared with hit addresses |
| rd_req_i | input | 1 | Readout allowed (output link free) |
| out_valid_o | output | 1 | out_data_o carries a selected word |
| out_data_o | output | DATA_W | Selected hit word |
| out_last_o | output | 1 | Completion of the current trigger |
| full_o | output | 1 | Trigger table or data store full |

## Verification
The hardest states to reach are the two overflow limits. The stimulus fills the data store to exactly its depth, once with no trigger pending and once behind a trigger whose readout is held off. It fills the trigger table to its last slot with readout blocked, and then offers one more trigger. A further case places a trigger, a hit and a frame-start strobe in the same cycle, so that the frame each of them belongs to becomes visible in the selected words.

// File: rtl/win_hit_pkg.sv
package win_hit_pkg;
  typedef enum logic [1:0] {
    EX_IDLE,
    EX_SCAN,
    EX_FLUSH
  } ex_state_e;
endpackage

// File: rtl/fhb_data_mem.sv
module fhb_data_mem #(
  parameter int DATA_W = 16,
  parameter int AW     = 10,
  localparam int PW    = AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [PW-1:0]     keep_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [PW-1:0]     wr_ptr_o,
  output logic [PW-1:0]     fill_o,
  output logic              full_o
);
  localparam logic [PW-1:0] ONE_P = 1;

  logic [DATA_W-1:0] mem_q [2**AW];
  logic [PW-1:0]     wr_q;
  logic              wr_en;

  assign fill_o   = wr_q - keep_i;
  assign full_o   = fill_o[PW-1];  // fill never exceeds the depth
  assign wr_en    = we_i && !full_o;
  assign wr_ptr_o = wr_q;
  assign rdata_o  = mem_q[raddr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_q <= '0;
    else if (wr_en) wr_q <= wr_q + ONE_P;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en) mem_q[wr_q[AW-1:0]] <= wdata_i;
  end
endmodule

// File: rtl/fhb_frame_tab.sv
module fhb_frame_tab #(
  parameter int FAW = 9,
  parameter int PW  = 11,
  parameter int NRD = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      frame_start_i,
  input  logic [FAW-1:0]            frame_cnt_i,
  input  logic [PW-1:0]             wr_ptr_i,
  input  logic [NRD-1:0][FAW-1:0]   raddr_i,
  output logic [NRD-1:0][PW-1:0]    rdata_o,
  output logic [FAW-1:0]            cur_frame_o,
  output logic                      frame_valid_o
);
  logic [PW-1:0] start_q [2**FAW];

  always_ff @(posedge clk_i) begin
    if (frame_start_i) start_q[frame_cnt_i] <= wr_ptr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_frame_o   <= '0;
      frame_valid_o <= 1'b0;
    end else if (frame_start_i) begin
      cur_frame_o   <= frame_cnt_i;
      frame_valid_o <= 1'b1;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata_o[g] = start_q[raddr_i[g]];
  end
endmodule

// File: rtl/fhb_trig_fifo.sv
module fhb_trig_fifo #(
  parameter int TW  = 12,
  parameter int FAW = 9,
  parameter int DAW = 9
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           push_i,
  input  logic [TW-1:0]  time_i,
  input  logic [FAW-1:0] frame_i,
  input  logic           pop_i,
  output logic [TW-1:0]  head_time_o,
  output logic [FAW-1:0] head_frame_o,
  output logic [DAW:0]   cnt_o,
  output logic           full_o,
  output logic           empty_o
);
  localparam int EW = TW + FAW;
  localparam logic [DAW:0] ONE_C = 1;

  logic [EW-1:0] ent_q [2**DAW];
  logic [DAW:0]  wp_q, rp_q;

  assign cnt_o   = wp_q - rp_q;
  assign full_o  = cnt_o[DAW];
  assign empty_o = (cnt_o == '0);
  assign {head_frame_o, head_time_o} = ent_q[rp_q[DAW-1:0]];

  always_ff @(posedge clk_i) begin
    if (push_i && !full_o) ent_q[wp_q[DAW-1:0]] <= {frame_i, time_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (push_i && !full_o) wp_q <= wp_q + ONE_C;
      if (pop_i && !empty_o) rp_q <= rp_q + ONE_C;
    end
  end
endmodule

// File: rtl/fhb_extract.sv
module fhb_extract
  import win_hit_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CMP_W  = 12,
  parameter int PW     = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [PW-1:0]     s0_i,
  input  logic [PW-1:0]     s1_i,
  input  logic [PW-1:0]     s2_i,
  input  logic [CMP_W-1:0]  ttime_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [PW-2:0]     raddr_o,
  output logic              pop_o,
  output logic              idle_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_last_o
);
  localparam logic [PW-1:0] ONE_P = 1;

  ex_state_e         st_q;
  logic [PW-1:0]     ptr_q, mid_q, end_q;
  logic [CMP_W-1:0]  tt_q;
  logic              second_q, pend_v_q;
  logic [DATA_W-1:0] pend_q;
  logic [CMP_W-1:0]  word_addr;
  logic              sel;
  logic [PW-1:0]     ptr_nxt;

  assign word_addr = rdata_i[CMP_W-1:0];
  assign sel       = second_q ? (word_addr < tt_q) : (word_addr > tt_q);
  assign ptr_nxt   = ptr_q + ONE_P;
  assign raddr_o   = ptr_q[PW-2:0];
  assign pop_o     = (st_q == EX_FLUSH);
  assign idle_o    = (st_q == EX_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= EX_IDLE;
      ptr_q       <= '0;
      mid_q       <= '0;
      end_q       <= '0;
      tt_q        <= '0;
      second_q    <= 1'b0;
      pend_v_q    <= 1'b0;
      pend_q      <= '0;
      out_valid_o <= 1'b0;
      out_last_o  <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= 1'b0;
      out_last_o  <= 1'b0;
      unique case (st_q)
        EX_IDLE: begin
          if (start_i) begin
            ptr_q    <= s0_i;
            mid_q    <= s1_i;
            end_q    <= s2_i;
            tt_q     <= ttime_i;
            second_q <= (s0_i == s1_i);
            pend_v_q <= 1'b0;
            st_q     <= EX_SCAN;
          end
        end
        EX_SCAN: begin
          if (ptr_q == end_q) begin
            st_q <= EX_FLUSH;
          end else begin
            // hold back one word so the final one can carry last
            if (sel) begin
              if (pend_v_q) begin
                out_valid_o <= 1'b1;
                out_data_o  <= pend_q;
              end
              pend_v_q <= 1'b1;
              pend_q   <= rdata_i;
            end
            ptr_q <= ptr_nxt;
            if (ptr_nxt == mid_q) second_q <= 1'b1;
          end
        end
        EX_FLUSH: begin
          out_valid_o <= pend_v_q;
          out_last_o  <= 1'b1;
          out_data_o  <= pend_q;
          st_q        <= EX_IDLE;
        end
        default: st_q <= EX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/win_hit_buffer.sv
module win_hit_buffer #(
  parameter int DATA_W   = 16,
  parameter int CMP_W    = 12,
  parameter int DMEM_AW  = 10,
  parameter int FRAME_AW = 9,
  parameter int TRIG_AW  = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                hit_valid_i,
  input  logic [DATA_W-1:0]   hit_data_i,
  input  logic                frame_start_i,
  input  logic [FRAME_AW-1:0] frame_cnt_i,
  input  logic                trig_i,
  input  logic [CMP_W-1:0]    trig_time_i,
  input  logic                rd_req_i,
  output logic                out_valid_o,
  output logic [DATA_W-1:0]   out_data_o,
  output logic                out_last_o,
  output logic                full_o
);
  localparam int PW = DMEM_AW + 1;
  localparam logic [FRAME_AW-1:0] ONE_F = 1;
  localparam logic [FRAME_AW-1:0] TWO_F = 2;

  logic [PW-1:0]               wr_ptr, data_fill, keep_ptr;
  logic                        data_full;
  logic [DATA_W-1:0]           dm_rdata;
  logic [DMEM_AW-1:0]          dm_raddr;
  logic [3:0][FRAME_AW-1:0]    ft_raddr;
  logic [3:0][PW-1:0]          ft_rdata;
  logic [FRAME_AW-1:0]         cur_frame, head_frame, frames_ahead;
  logic                        frame_valid;
  logic [CMP_W-1:0]            head_time;
  logic [TRIG_AW:0]            trig_cnt;
  logic                        trig_full, trig_empty, trig_push;
  logic                        ex_start, ex_pop, ex_idle;

  assign full_o       = data_full | trig_full;
  assign trig_push    = trig_i && !full_o && frame_valid;
  assign frames_ahead = cur_frame - head_frame;
  assign ex_start     = ex_idle && rd_req_i && !trig_empty && (frames_ahead >= TWO_F);

  assign ft_raddr[0] = head_frame;
  assign ft_raddr[1] = head_frame + ONE_F;
  assign ft_raddr[2] = head_frame + TWO_F;
  assign ft_raddr[3] = cur_frame;

  // oldest protected frame start: pending trigger, else current frame
  always_comb begin
    if (!trig_empty)      keep_ptr = ft_rdata[0];
    else if (frame_valid) keep_ptr = ft_rdata[3];
    else                  keep_ptr = wr_ptr;
  end

  fhb_data_mem #(.DATA_W(DATA_W), .AW(DMEM_AW)) u_dmem (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (hit_valid_i),
    .wdata_i  (hit_data_i),
    .keep_i   (keep_ptr),
    .raddr_i  (dm_raddr),
    .rdata_o  (dm_rdata),
    .wr_ptr_o (wr_ptr),
    .fill_o   (data_fill),
    .full_o   (data_full)
  );

  fhb_frame_tab #(.FAW(FRAME_AW), .PW(PW), .NRD(4)) u_ftab (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_start_i (frame_start_i),
    .frame_cnt_i   (frame_cnt_i),
    .wr_ptr_i      (wr_ptr),
    .raddr_i       (ft_raddr),
    .rdata_o       (ft_rdata),
    .cur_frame_o   (cur_frame),
    .frame_valid_o (frame_valid)
  );

  fhb_trig_fifo #(.TW(CMP_W), .FAW(FRAME_AW), .DAW(TRIG_AW)) u_tfifo (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (trig_push),
    .time_i       (trig_time_i),
    .frame_i      (cur_frame),
    .pop_i        (ex_pop),
    .head_time_o  (head_time),
    .head_frame_o (head_frame),
    .cnt_o        (trig_cnt),
    .full_o       (trig_full),
    .empty_o      (trig_empty)
  );

  fhb_extract #(.DATA_W(DATA_W), .CMP_W(CMP_W), .PW(PW)) u_ext (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (ex_start),
    .s0_i        (ft_rdata[0]),
    .s1_i        (ft_rdata[1]),
    .s2_i        (ft_rdata[2]),
    .ttime_i     (head_time),
    .rdata_i     (dm_rdata),
    .raddr_o     (dm_raddr),
    .pop_o       (ex_pop),
    .idle_o      (ex_idle),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o),
    .out_last_o  (out_last_o)
  );
endmodule

// File: rtl/win_hit_buffer_chk.sv
module win_hit_buffer_chk #(
  parameter int TRIG_AW = 9,
  parameter int DMEM_AW = 10
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               trig_i,
  input logic               full_o,
  input logic               out_valid_o,
  input logic               out_last_o,
  input logic [TRIG_AW:0]   trig_cnt,
  input logic [DMEM_AW:0]   data_fill
);
  localparam logic [TRIG_AW:0] TDEPTH = {1'b1, {TRIG_AW{1'b0}}};
  localparam logic [DMEM_AW:0] DDEPTH = {1'b1, {DMEM_AW{1'b0}}};

  AST_TRIG_DROP_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && trig_i) |=> (trig_cnt <= $past(trig_cnt))); // R6

  AST_TRIG_FULL_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_cnt == TDEPTH) |-> full_o); // R6

  AST_DATA_NO_OVERRUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_fill <= DDEPTH); // R1

  AST_LAST_HAS_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> ($past(trig_cnt) != '0)); // R4

  AST_VALID_HAS_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ($past(trig_cnt) != '0)); // R5
endmodule

bind win_hit_buffer win_hit_buffer_chk #(.TRIG_AW(TRIG_AW), .DMEM_AW(DMEM_AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .trig_i      (trig_i),
  .full_o      (full_o),
  .out_valid_o (out_valid_o),
  .out_last_o  (out_last_o),
  .trig_cnt    (trig_cnt),
  .data_fill   (data_fill)
);

// File: tb/win_hit_buffer_tb_top.sv
`timescale 1ns/1ps
module win_hit_buffer_tb_top;
  localparam int DEPTH  = 1024;
  localparam int TDEPTH = 512;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hit_valid_i = 1'b0;
  logic [15:0] hit_data_i = '0;
  logic        frame_start_i = 1'b0;
  logic [8:0]  frame_cnt_i = '0;
  logic        trig_i = 1'b0;
  logic [11:0] trig_time_i = '0;
  logic        rd_req_i = 1'b1;
  logic        out_valid_o, out_last_o, full_o;
  logic [15:0] out_data_o;

  always #10 clk = ~clk;

  win_hit_buffer dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .hit_valid_i(hit_valid_i), .hit_data_i(hit_data_i),
    .frame_start_i(frame_start_i), .frame_cnt_i(frame_cnt_i), .trig_i(trig_i),
    .trig_time_i(trig_time_i), .rd_req_i(rd_req_i), .out_valid_o(out_valid_o),
    .out_data_o(out_data_o), .out_last_o(out_last_o), .full_o(full_o)
  );

  int n_chk = 0, n_err = 0, n_done = 0, n_empty = 0;
  bit checks_on = 0;

  // reference model state
  int hmem [int];
  int fst [int];
  int wr_cnt = 0, cur = 0, fnext = 0;
  bit fvalid = 0;
  int trig_t [$];
  int trig_f [$];
  int exp_q [$];
  bit built = 0;
  int idx = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 'h%0h expected 'h%0h", tag, act, exp);
    end
  endtask

  function automatic int m_keep();
    if (trig_f.size() != 0) return fst[trig_f[0]];
    if (fvalid) return fst[cur];
    return wr_cnt;
  endfunction

  function automatic bit m_dfull();
    return (wr_cnt - m_keep()) >= DEPTH;
  endfunction

  function automatic bit m_full();
    return m_dfull() || (trig_t.size() == TDEPTH);
  endfunction

  task automatic build(input int t, input int f);
    exp_q.delete();
    for (int i = fst[f]; i < fst[f+1]; i++) if ((hmem[i] & 'hfff) > t) exp_q.push_back(hmem[i]);
    for (int i = fst[f+1]; i < fst[f+2]; i++) if ((hmem[i] & 'hfff) < t) exp_q.push_back(hmem[i]);
  endtask

  // model update on the active edge from inputs that are stable there
  always @(posedge clk) begin
    if (rst_ni) begin
      bit acc_t, acc_h;
      int old_cur;
      acc_t = trig_i && !m_full() && fvalid;
      acc_h = hit_valid_i && !m_dfull();
      old_cur = cur;
      if (frame_start_i) fst[int'(frame_cnt_i)] = wr_cnt;
      if (acc_h) begin
        hmem[wr_cnt] = int'(hit_data_i);
        wr_cnt++;
      end
      if (frame_start_i) begin
        cur = int'(frame_cnt_i);
        fvalid = 1;
      end
      if (acc_t) begin
        trig_t.push_back(int'(trig_time_i));
        trig_f.push_back(old_cur);
      end
    end
  end

  // output comparison away from the active edge
  always @(negedge clk) begin
    if (checks_on) begin
      if (out_valid_o || out_last_o) begin
        if (trig_t.size() == 0) begin
          chk(0, "R5 output with no pending trigger", 1, 0);
        end else begin
          if (!built) begin
            chk((cur - trig_f[0]) >= 2, "R5 frame distance at start", cur - trig_f[0], 2);
            build(trig_t[0], trig_f[0]);
            built = 1;
            idx = 0;
          end
          if (out_valid_o) begin
            chk(idx < exp_q.size() && int'(out_data_o) == exp_q[idx], "R2 R3 selected word",
                int'(out_data_o), (idx < exp_q.size()) ? exp_q[idx] : -1);
            chk(out_last_o == (idx == exp_q.size() - 1), "R4 last on final word",
                int'(out_last_o), int'(idx == exp_q.size() - 1));
            idx++;
          end else begin
            chk(exp_q.size() == 0, "R4 empty marker", 0, exp_q.size());
            n_empty++;
          end
          if (out_last_o) begin
            void'(trig_t.pop_front());
            void'(trig_f.pop_front());
            built = 0;
            n_done++;
          end
        end
      end
      chk(full_o == m_full(), "R1 R6 full_o", int'(full_o), int'(m_full()));
    end
  end

  task automatic cyc(input bit hv, input int hd, input bit fs, input bit tr, input int tt);
    @(negedge clk);
    hit_valid_i   = hv;
    hit_data_i    = 16'(hd);
    frame_start_i = fs;
    frame_cnt_i   = 9'(fnext);
    if (fs) fnext++;
    trig_i        = tr;
    trig_time_i   = 12'(tt);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask
  task automatic hit(input int d);   cyc(1, d, 0, 0, 0); endtask
  task automatic frame();            cyc(0, 0, 1, 0, 0); endtask
  task automatic trig(input int t);  cyc(0, 0, 0, 1, t); endtask

  initial begin
    int base, e0;
    repeat (3) @(negedge clk);
    #5;
    chk(out_valid_o == 0 && out_last_o == 0, "R9 outputs at reset", int'(out_valid_o | out_last_o), 0);
    chk(full_o == 0, "R9 full at reset", int'(full_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    checks_on = 1;
    #5;
    chk(full_o == 0 && out_valid_o == 0, "R9 after reset release", int'(full_o), 0);

    // trigger before any frame is dropped (R6)
    trig(12'h001);
    // basic window
    frame();
    hit(16'h0050); hit(16'hF200); trig(12'h100); hit(16'h3100); hit(16'h0101);
    frame();
    hit(16'h00FF); hit(16'h7100); hit(16'hA050); hit(16'h0300);
    frame();
    idle(30);
    #5 chk(n_done == 1, "R3 basic window completed", n_done, 1);

    // empty trigger
    e0 = n_empty;
    hit(16'h0000); trig(12'h000);
    frame(); hit(16'h0005);
    frame(); idle(20);
    #5 chk(n_empty == e0 + 1, "R4 empty completion", n_empty, e0 + 1);

    // trigger, hit and frame strobe in one cycle (R2)
    hit(16'h0350);
    cyc(1, 16'h0400, 1, 1, 12'h300);
    hit(16'h0200);
    frame(); idle(20);
    #5 chk(n_done == 3, "R2 same-cycle trigger completed", n_done, 3);

    // needs two frames past its own (R5)
    base = n_done;
    hit(16'h0900); trig(12'h800);
    frame(); idle(20);
    #5 chk(n_done == base, "R5 held one frame after", n_done, base);
    frame(); idle(20);
    #5 chk(n_done == base + 1, "R5 released two frames after", n_done, base + 1);

    // pending triggers held while link busy (R7)
    base = n_done;
    rd_req_i = 1'b0;
    for (int k = 0; k < 10; k++) begin
      hit(k * 'h40 + 3); hit(k * 'h40 + 'h45); trig(k * 'h40 + 4);
      frame();
    end
    frame(); idle(50);
    #5 chk(n_done == base, "R7 no output while rd_req low", n_done, base);
    rd_req_i = 1'b1;
    idle(300);
    #5 chk(n_done == base + 10, "R7 all held triggers completed", n_done, base + 10);

    // data full with nothing pending, cleared by frame start (R1 R8)
    frame();
    for (int i = 0; i < DEPTH + 6; i++) hit(i);
    idle(1);
    #5 chk(full_o == 1, "R1 data full", int'(full_o), 1);
    frame(); idle(1);
    #5 chk(full_o == 0, "R8 frame start clears full", int'(full_o), 0);

    // trigger table full (R6)
    base = n_done;
    frame();
    hit(16'h0A00); hit(16'h0B00);
    rd_req_i = 1'b0;
    for (int i = 0; i < TDEPTH + 1; i++) trig(12'h900);
    idle(1);
    #5 chk(full_o == 1, "R6 trigger table full", int'(full_o), 1);
    frame(); hit(16'h0100);
    frame();
    rd_req_i = 1'b1;
    idle(TDEPTH * 8);
    #5 chk(n_done == base + TDEPTH, "R6 extra trigger dropped", n_done, base + TDEPTH);

    // data full behind a pending trigger, released by checkout (R8)
    base = n_done;
    rd_req_i = 1'b0;
    frame();
    trig(12'h010); hit(16'h0020);
    frame();
    for (int i = 0; i < DEPTH + 4; i++) hit(i & 'h1f);
    idle(1);
    #5 chk(full_o == 1, "R1 data full behind trigger", int'(full_o), 1);
    frame();
    rd_req_i = 1'b1;
    idle(DEPTH + 200);
    #5 chk(n_done == base + 1, "R8 protected trigger completed", n_done, base + 1);
    chk(full_o == 0, "R8 checkout releases space", int'(full_o), 0);

    idle(10);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule